// File: doc/BRIEF.md
# Combined Enable/Status Interrupt Aggregator

This block gathers a small, parameterised group of interrupt inputs into one interrupt line toward a parent controller. Each input owns a sticky pending flag and an enable flag. Both sets of flags live in a single 32-bit register: the enable flags are in the low half and the pending flags in the high half. Each pending flag sits exactly 16 places above its own enable flag. The group of inputs can begin at a non-zero bit position inside each half, so the same block serves a seven-input group at position 0, a six-input group at position 0, or a two-input group at bits 4 and 5.

A rising edge on an input latches its pending flag, whatever the enable state. Software masks or unmasks an input by writing its enable flag. It acknowledges an input by writing a one to that input's pending flag. Pending flags ignore written zeros, so software can rewrite the enables with zeros in the upper half without losing events. The combined output is the registered OR of the pending flags that are also enabled. It stays high while any enabled flag is pending, so it behaves as a level interrupt. Software services each input in turn, lowest first, and clears each one separately.

Top module: `evtc_top`

## Requirements
- R1: After a synchronous reset, every enable and pending flag is zero, `irq_out` is low and `rd_valid` is low.
- R2: A 0-to-1 change on `src_i[n]` sets the pending flag at register bit `BIT_OFS+n+16`, whether or not input n is enabled. An input held high does not set the flag again once the flag has been cleared.
- R3: A register write with a one at bit `BIT_OFS+n+16` clears pending flag n. A zero at that bit leaves the flag unchanged.
- R4: A register write loads enable flag n from bit `BIT_OFS+n`. Pending flags are not disturbed when the write carries zeros in the upper half.
- R5: `irq_out` is a register whose next value is the OR over n of (pending n AND enable n). A pending flag whose enable is zero does not raise `irq_out`.
- R6: When a rising edge and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: Register bits outside the enable and pending fields read as zero, and writes to them have no effect.
- R8: A read request (`req_valid`=1, `req_write`=0) gives `rd_valid`=1 one cycle later. `rd_data` then holds the register image as it was when the request was accepted. A request whose `req_addr` differs from `REG_ADDR` reads zero and does not write.
- R9: `irq_out` falls one cycle after the clock edge that removes the last enabled pending flag.
- R10: The field position is set by `BIT_OFS`. With 2 inputs at offset 4, input 1 uses enable bit 5 and pending bit 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Interrupt inputs, sampled for rising edges |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address; only `REG_ADDR` is decoded |
| req_wdata | input | 32 | Write data: enables in the low half, write-one-to-clear pending flags in the high half |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The bound checker checks the cycle-level rules on every clock. These are: an input edge always sets its flag, even against a clearing write; pending flags and enables change only through a decoded write; `irq_out` follows the enabled-pending OR one edge later; reads answer in one cycle; and bits outside the fields read as zero. The bench's scenarios cover what a per-cycle property cannot see at the ports. These are: the exact register image after mixed writes, a masked flag that is kept but not signalled, a held level that does not set its flag again after an acknowledge, accesses to a foreign address being ignored, and the shifted field layout of a second instance at offset 4.

// File: rtl/evtc_pkg.sv
package evtc_pkg;
  localparam int WORD_W    = 32;
  localparam int STS_SHIFT = 16;

  typedef logic [WORD_W-1:0] word_t;

  // Bits of the register that belong to the enable and pending fields.
  function automatic word_t field_mask(input int nsrc, input int ofs);
    word_t m;
    m = '0;
    for (int i = 0; i < nsrc; i++) begin
      m = m | (word_t'(1) << (ofs + i));
      m = m | (word_t'(1) << (ofs + i + STS_SHIFT));
    end
    return m;
  endfunction
endpackage

// File: rtl/evtc_cell.sv
// One input: edge detector, sticky pending flag, enable flag.
module evtc_cell (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic wr_stb,
  input  logic en_wr,
  input  logic clr_wr,
  output logic en_q,
  output logic sts_q
);
  logic src_q;
  logic rise;

  assign rise = src & ~src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= 1'b0;
      en_q  <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      src_q <= src;
      if (wr_stb) en_q <= en_wr;
      // a new event outranks an acknowledge in the same cycle
      if (rise)                  sts_q <= 1'b1;
      else if (wr_stb && clr_wr) sts_q <= 1'b0;
    end
  end
endmodule

// File: rtl/evtc_bus.sv
// Address decode and registered read port.
module evtc_bus
  import evtc_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  word_t             image,
  output logic              wr_stb,
  output logic              rd_valid,
  output word_t             rd_data
);
  logic hit;
  logic rd_req;

  assign hit    = (req_addr == REG_ADDR);
  assign rd_req = req_valid & ~req_write;
  assign wr_stb = req_valid & req_write & hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= (rd_req && hit) ? image : '0;
    end
  end
endmodule

// File: rtl/evtc_merge.sv
// Registered OR of enabled pending flags.
module evtc_merge #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend,
  output logic               irq_out
);
  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |pend;
  end
endmodule

// File: rtl/evtc_top.sv
module evtc_top
  import evtc_pkg::*;
#(
  parameter int                NUM_SRC  = 7,
  parameter int                BIT_OFS  = 0,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rd_valid,
  output logic [31:0]        rd_data,
  output logic               irq_out
);
  localparam word_t FMASK = field_mask(NUM_SRC, BIT_OFS);

  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] sts_vec;
  logic [NUM_SRC-1:0] pend_vec;
  logic               wr_stb;
  word_t              image;
  logic               unused_wdata_bits;

  assign unused_wdata_bits = ^(req_wdata & ~FMASK);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    evtc_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .src    (src_i[i]),
      .wr_stb (wr_stb),
      .en_wr  (req_wdata[BIT_OFS + i]),
      .clr_wr (req_wdata[BIT_OFS + i + STS_SHIFT]),
      .en_q   (en_vec[i]),
      .sts_q  (sts_vec[i])
    );
  end

  assign pend_vec = sts_vec & en_vec;

  always_comb begin
    image = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      image = image | (word_t'(en_vec[i])  << (BIT_OFS + i));
      image = image | (word_t'(sts_vec[i]) << (BIT_OFS + i + STS_SHIFT));
    end
  end

  evtc_bus #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
  ) u_bus (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .image     (image),
    .wr_stb    (wr_stb),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  evtc_merge #(
    .NUM_SRC (NUM_SRC)
  ) u_merge (
    .clk     (clk),
    .rst     (rst),
    .pend    (pend_vec),
    .irq_out (irq_out)
  );
endmodule

// File: rtl/evtc_chk.sv
module evtc_chk
  import evtc_pkg::*;
#(
  parameter int                NUM_SRC  = 7,
  parameter int                BIT_OFS  = 0,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src,
  input logic               req_valid,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               rd_valid,
  input logic [31:0]        rd_data,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] en,
  input logic [NUM_SRC-1:0] sts
);
  localparam word_t FMASK = field_mask(NUM_SRC, BIT_OFS);

  logic [NUM_SRC-1:0] src_d;
  logic               wr_hit;
  logic               rd_req;

  assign wr_hit = req_valid && req_write && (req_addr == REG_ADDR);
  assign rd_req = req_valid && !req_write;

  always_ff @(posedge clk) begin
    if (rst) src_d <= '0;
    else     src_d <= src;
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!irq_out && !rd_valid && en == '0 && sts == '0));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // R2 and R6: an edge always leaves the flag set
    a_r2_edge_sets: assert property (@(posedge clk) disable iff (rst)
      (src[i] && !src_d[i]) |=> sts[i]);
    // R3: only a decoded write can clear a flag
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
      (sts[i] && !wr_hit) |=> sts[i]);
  end

  // R4: enables change only through a decoded write
  a_r4_en_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(en));

  // R5
  a_r5_irq_high: assert property (@(posedge clk) disable iff (rst)
    (|(sts & en)) |=> irq_out);
  a_r5_irq_low: assert property (@(posedge clk) disable iff (rst)
    !(|(sts & en)) |=> !irq_out);

  // R7
  a_r7_outside_zero: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ((rd_data & ~FMASK) == '0));

  // R8
  a_r8_rd_latency: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  a_r8_rd_quiet: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);
endmodule

bind evtc_top evtc_chk #(
  .NUM_SRC  (NUM_SRC),
  .BIT_OFS  (BIT_OFS),
  .ADDR_W   (ADDR_W),
  .REG_ADDR (REG_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src       (src_i),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .irq_out   (irq_out),
  .en        (en_vec),
  .sts       (sts_vec)
);

// File: tb/evtc_top_test.sv
module evtc_top_test;
  localparam logic [7:0] REG = 8'h20;

  typedef struct packed {
    logic        do_wr;
    logic [6:0]  src;
    logic [31:0] wdata;
    logic [31:0] exp_img;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 7'h00, 32'h0000_0000, 32'h0000_0000, 1'b0, 4'd1},  // R1 idle
    '{1'b0, 7'h01, 32'h0000_0000, 32'h0001_0000, 1'b0, 4'd2},  // R2 edge while disabled
    '{1'b1, 7'h01, 32'h0000_0001, 32'h0001_0001, 1'b1, 4'd4},  // R4 enable keeps pending
    '{1'b1, 7'h01, 32'hFF80_FF81, 32'h0001_0001, 1'b1, 4'd7},  // R7 outside bits ignored
    '{1'b1, 7'h00, 32'h0001_0001, 32'h0000_0001, 1'b0, 4'd3},  // R3 clear by one
    '{1'b1, 7'h42, 32'h0000_0041, 32'h0042_0041, 1'b1, 4'd2},  // R2 two edges
    '{1'b1, 7'h42, 32'h0040_0043, 32'h0002_0043, 1'b1, 4'd3},  // R3 selective clear
    '{1'b1, 7'h00, 32'h0000_0041, 32'h0002_0041, 1'b0, 4'd5},  // R5 masked pending
    '{1'b1, 7'h01, 32'h0001_0041, 32'h0003_0041, 1'b1, 4'd6},  // R6 set beats clear
    '{1'b1, 7'h00, 32'h007F_0000, 32'h0000_0000, 1'b0, 4'd3},  // R3 clear all
    '{1'b0, 7'h7F, 32'h0000_0000, 32'h007F_0000, 1'b0, 4'd2},  // R2 all edges
    '{1'b1, 7'h7F, 32'h0000_007F, 32'h007F_007F, 1'b1, 4'd5},  // R5 all enabled
    '{1'b1, 7'h7F, 32'h007F_007F, 32'h0000_007F, 1'b0, 4'd2}   // R2 held level no reset
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  src_i = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = REG;
  logic [31:0] req_wdata = '0;
  logic        rd_valid, irq_out;
  logic [31:0] rd_data;

  logic [1:0]  b_src = '0;
  logic        b_valid = 1'b0, b_write = 1'b0;
  logic [31:0] b_wdata = '0;
  logic        b_rd_valid, b_irq;
  logic [31:0] b_rd_data;

  int checks = 0, errs = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evtc_top uut (
    .clk(clk), .rst(rst), .src_i(src_i),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq_out(irq_out)
  );

  evtc_top #(.NUM_SRC(2), .BIT_OFS(4)) uut_b (
    .clk(clk), .rst(rst), .src_i(b_src),
    .req_valid(b_valid), .req_write(b_write), .req_addr(REG),
    .req_wdata(b_wdata), .rd_valid(b_rd_valid), .rd_data(b_rd_data),
    .irq_out(b_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access; returns at the falling edge after the accepting clock edge.
  task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_addr = REG;
  endtask

  task automatic b_access(input logic w, input logic [31:0] d);
    @(negedge clk);
    b_valid = 1'b1; b_write = w; b_wdata = d;
    @(negedge clk);
    b_valid = 1'b0; b_write = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
    chk("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
    access(1'b0, REG, '0);
    chk("R8 rd_valid after read", {31'b0, rd_valid}, 32'h1);
    chk("R1 image", rd_data, 32'h0);
    @(negedge clk);
    chk("R8 rd_valid drops", {31'b0, rd_valid}, 32'h0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      src_i = VEC[k].src;
      if (VEC[k].do_wr) begin
        req_valid = 1'b1; req_write = 1'b1; req_wdata = VEC[k].wdata;
      end
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk($sformatf("R%0d vec%0d image", VEC[k].req, k), rd_data, VEC[k].exp_img);
      chk($sformatf("R%0d vec%0d irq", VEC[k].req, k), {31'b0, irq_out}, {31'b0, VEC[k].exp_irq});
    end

    // R8: foreign address neither writes nor reads
    access(1'b1, 8'h24, 32'h007F_0000);
    access(1'b0, 8'h24, '0);
    chk("R8 foreign read", rd_data, 32'h0);
    access(1'b0, REG, '0);
    chk("R8 foreign write ignored", rd_data, 32'h0000_007F);

    // R9: deassert lag
    @(negedge clk); src_i = 7'h00;
    @(negedge clk); src_i = 7'h01;
    @(negedge clk); @(negedge clk);
    chk("R9 irq before clear", {31'b0, irq_out}, 32'h1);
    access(1'b1, REG, 32'h0001_007F);
    chk("R9 irq one cycle after clear", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    chk("R9 irq low", {31'b0, irq_out}, 32'h0);

    // R10: two inputs at offset 4
    @(negedge clk); b_src = 2'b10;
    b_access(1'b1, 32'h0000_0020);
    @(negedge clk);
    chk("R10 irq offset", {31'b0, b_irq}, 32'h1);
    b_access(1'b0, '0);
    chk("R10 image offset", b_rd_data, 32'h0020_0020);
    b_access(1'b1, 32'hFFFF_FFFF);
    b_access(1'b0, '0);
    chk("R10 R7 image after all-ones", b_rd_data, 32'h0000_0030);
    @(negedge clk);
    chk("R10 irq cleared", {31'b0, b_irq}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule